// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the architectural state update that a scalar processor core makes when it takes an exception. The pipeline presents a one-cycle strobe with a fault kind, a coprocessor number, the faulting virtual address, the translation tag fields, and the program counter pair of the faulting instruction. In that same clock edge the block updates its status, cause, exception PC, bad-address, translation-tag, page-context and shadow-register-control registers. It also computes the handler address from the vector base, the exception level, the boot-vector flag and the interrupt-vector flag.

One cycle after the strobe, the block drives a single-cycle redirect pulse carrying the new fetch PC and the two sequential PCs that follow it. After reset the block issues one boot redirect on its own.

A small control machine sequences this. ST_BOOT is entered from reset. It leaves to ST_RUN on the first clock edge, and that edge issues the boot redirect. ST_RUN loops on itself and accepts exception strobes. The vector base can be loaded through a write port. All registers can be observed through a combinational debug read port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset is released, the first clock edge leaves ST_BOOT and produces one redirect pulse with PC 0xBFC00000, next PC 0xBFC00004 and next-next PC 0xBFC00008. The same edge sets Status.CU1 (bit 29). Status.EXL (bit 1) stays 0, and Status.BEV (bit 22) reads as the BEV_INIT parameter.
- R2: Every accepted exception (kind codes 0 to 13) sets Status.EXL to 1, including when it is already 1. EXL never clears.
- R3: Shadow control holds the current set in bits 3:0, the previous set in bits 9:6 and the exception set in bits 15:12. If EXL and BEV are both 0 on entry, the previous set receives the current set and the current set receives the exception set. Otherwise the register is unchanged.
- R4: Next PC differing from PC+4 means a branch delay slot. In that case EPC = PC-4 and Cause.BD (bit 31) = 1. Otherwise EPC = PC and BD = 0.
- R5: Cause.ExcCode (bits 6:2) takes the code for the kind, and Cause.CE (bits 29:28) is cleared. The kind-to-code map is:
  - 0 interrupt→0x0
  - 1 page-modified→0x1
  - 2 translation load/fetch→0x2
  - 3 translation store→0x3
  - 4 address load→0x4
  - 5 address store→0x5
  - 6 syscall→0x8
  - 7 breakpoint→0x9
  - 8 reserved instruction→0xA
  - 9 coprocessor unusable→0xB
  - 10 overflow→0xC
  - 11 trap→0xD
  - 12 refill load→0x2
  - 13 refill store→0x3
- R6: For kind 9, Cause.CE takes the coprocessor number input.
- R7: Unless a rule below applies, the handler is EBASE+0x180.
- R8: For refill kinds 12 and 13, the handler is EBASE+0x000 if EXL was 0 before the entry and EBASE+0x180 if it was 1.
- R9: For kind 0, the handler is EBASE+0x200 when Cause.IV (bit 23, value IV_INIT) is 1, and EBASE+0x180 otherwise.
- R10: For kind 10 with BEV set, the handler is 0xBFC00200.
- R11: The redirect pulse is high for exactly the cycle after each accepted strobe, with next PC = handler+4 and next-next PC = handler+8.
- R12: Kinds 1 to 5, 12 and 13 write the fault address into BadVAddr. Kinds 1, 2, 3, 12 and 13 also load EntryHi (VPN2 in bits 31:13, ASID in bits 7:0) and Context.BadVPN2 (bits 22:4). All other kinds leave these three registers unchanged.
- R13: Kind 15 is ignored: it produces no redirect and changes no register. Kind 14 redirects to 0xBFC00000 and sets CU1 only.
- R14: A vector-base write stores the data with bits 11:0 forced to 0, and later handlers use the new base. Debug select codes are: 0 status, 1 cause, 2 EPC, 3 BadVAddr, 4 EntryHi, 5 Context, 6 shadow control, 7 vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_valid | input | 1 | Exception strobe |
| ent_kind | input | 4 | Fault kind code |
| ent_cp_id | input | 2 | Offending coprocessor number |
| ent_addr | input | 32 | Faulting virtual address |
| ent_vpn2 | input | 19 | Translation tag page pair number |
| ent_asid | input | 8 | Translation address-space id |
| cur_pc | input | 32 | PC of faulting instruction |
| cur_npc | input | 32 | Next PC at the fault |
| vbase_we | input | 1 | Vector base write enable |
| vbase_wdata | input | 32 | Vector base write data |
| dbg_sel | input | 3 | Debug register select |
| dbg_rdata | output | 32 | Debug read data |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | 32 | New PC |
| redir_npc | output | 32 | New next PC |
| redir_nnpc | output | 32 | New next-next PC |

## Verification
The bench sweeps every kind code on two configurations: one with boot-vector and interrupt-vector flags clear, one with both set. It alternates delay-slot and sequential PC pairs, and checks cause, EPC, shadow control and the translation registers after each entry. The sweep targets these failure modes:
- A design that samples EXL after setting it would send a first refill to EBASE+0x180 instead of the base.
- A design that swaps shadow sets unconditionally would corrupt the register on a second nested entry.
- Wrong delay-slot detection would show as an EPC off by four.

Further checks cover the ignored kind code, the reset kind, the vector-base write with masking, and the end of the pulse after one cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN    = 32;
    localparam int VPN2_W  = 19;
    localparam int ASID_W  = 8;
    localparam int CPID_W  = 2;
    localparam int INSN_B  = 4;

    // status bit positions
    localparam int ST_EXL_BIT = 1;
    localparam int ST_BEV_BIT = 22;
    localparam int ST_CU1_BIT = 29;
    // cause bit positions
    localparam int CA_BD_BIT  = 31;
    localparam int CA_CE_LSB  = 28;
    localparam int CA_IV_BIT  = 23;
    localparam int CA_EXC_LSB = 2;
    // shadow control
    localparam int SH_CUR_LSB = 0;
    localparam int SH_PRV_LSB = 6;
    localparam int SH_EXC_LSB = 12;
    // translation tag fields
    localparam int HI_VPN_LSB  = 13;
    localparam int CTX_VPN_LSB = 4;

    localparam logic [XLEN-1:0] BOOT_VEC    = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BEV_OVF_VEC = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFS_GEN     = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_IRQ     = 32'h0000_0200;
    localparam logic [XLEN-1:0] VBASE_MASK  = 32'hFFFF_F000;

    typedef enum logic [3:0] {
        FK_INT       = 4'd0,
        FK_PG_MOD    = 4'd1,
        FK_TLB_LD    = 4'd2,
        FK_TLB_ST    = 4'd3,
        FK_ADR_LD    = 4'd4,
        FK_ADR_ST    = 4'd5,
        FK_SYSCALL   = 4'd6,
        FK_BREAK     = 4'd7,
        FK_RSVD      = 4'd8,
        FK_CPU       = 4'd9,
        FK_OVF       = 4'd10,
        FK_TRAP      = 4'd11,
        FK_REFILL_LD = 4'd12,
        FK_REFILL_ST = 4'd13,
        FK_RESET     = 4'd14,
        FK_NONE      = 4'd15
    } fault_kind_e;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    function automatic logic [4:0] exc_code_of(input fault_kind_e k);
        logic [4:0] c;
        unique case (k)
            FK_PG_MOD:               c = 5'h01;
            FK_TLB_LD, FK_REFILL_LD: c = 5'h02;
            FK_TLB_ST, FK_REFILL_ST: c = 5'h03;
            FK_ADR_LD:               c = 5'h04;
            FK_ADR_ST:               c = 5'h05;
            FK_SYSCALL:              c = 5'h08;
            FK_BREAK:                c = 5'h09;
            FK_RSVD:                 c = 5'h0A;
            FK_CPU:                  c = 5'h0B;
            FK_OVF:                  c = 5'h0C;
            FK_TRAP:                 c = 5'h0D;
            default:                 c = 5'h00;
        endcase
        return c;
    endfunction

    function automatic logic is_tlb_kind(input fault_kind_e k);
        return (k == FK_PG_MOD) || (k == FK_TLB_LD) || (k == FK_TLB_ST) ||
               (k == FK_REFILL_LD) || (k == FK_REFILL_ST);
    endfunction

    function automatic logic loads_badaddr(input fault_kind_e k);
        return is_tlb_kind(k) || (k == FK_ADR_LD) || (k == FK_ADR_ST);
    endfunction

endpackage

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] epc,
    output logic            in_slot
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

    always_comb begin
        in_slot = (npc != (pc + STEP));
        epc     = in_slot ? (pc - STEP) : pc;
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
(
    input  fault_kind_e     kind,
    input  logic            exl_before,
    input  logic            bev,
    input  logic            iv,
    input  logic [XLEN-1:0] vbase,
    output logic [XLEN-1:0] handler
);
    logic [XLEN-1:0] gen_vec;
    logic [XLEN-1:0] irq_vec;

    always_comb begin
        gen_vec = vbase + OFS_GEN;
        irq_vec = vbase + OFS_IRQ;
        unique case (kind)
            FK_REFILL_LD, FK_REFILL_ST: handler = exl_before ? gen_vec : vbase;
            FK_INT:                     handler = iv ? irq_vec : gen_vec;
            FK_OVF:                     handler = bev ? BEV_OVF_VEC : gen_vec;
            default:                    handler = gen_vec;
        endcase
    end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_entry_pkg::*;
#(
    parameter bit              BEV_INIT   = 1'b0,
    parameter bit              IV_INIT    = 1'b0,
    parameter logic [3:0]      CSS_INIT   = 4'd1,
    parameter logic [3:0]      ESS_INIT   = 4'd3,
    parameter logic [XLEN-1:0] VBASE_INIT = 32'h8000_0000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              boot_evt,
    input  fault_kind_e       kind,
    input  logic [CPID_W-1:0] cp_id,
    input  logic [XLEN-1:0]   bad_addr,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    input  logic [XLEN-1:0]   epc_in,
    input  logic              slot_in,
    input  logic              vbase_we,
    input  logic [XLEN-1:0]   vbase_wdata,
    input  logic [2:0]        dbg_sel,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic              exl_o,
    output logic              bev_o,
    output logic              iv_o,
    output logic [XLEN-1:0]   vbase_o
);
    logic              exl_q, cu1_q, bd_q;
    logic [CPID_W-1:0] ce_q;
    logic [4:0]        code_q;
    logic [XLEN-1:0]   epc_q, bad_q, vbase_q;
    logic [VPN2_W-1:0] hi_vpn_q, ctx_vpn_q;
    logic [ASID_W-1:0] hi_asid_q;
    logic [3:0]        css_q, pss_q;
    logic              swap;

    assign swap = take && !exl_q && !BEV_INIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exl_q     <= 1'b0;
            cu1_q     <= 1'b0;
            bd_q      <= 1'b0;
            ce_q      <= '0;
            code_q    <= '0;
            epc_q     <= '0;
            bad_q     <= '0;
            vbase_q   <= VBASE_INIT & VBASE_MASK;
            hi_vpn_q  <= '0;
            ctx_vpn_q <= '0;
            hi_asid_q <= '0;
            css_q     <= CSS_INIT;
            pss_q     <= '0;
        end else begin
            if (boot_evt) cu1_q <= 1'b1;
            if (vbase_we) vbase_q <= vbase_wdata & VBASE_MASK;
            if (take) begin
                exl_q  <= 1'b1;
                bd_q   <= slot_in;
                code_q <= exc_code_of(kind);
                ce_q   <= (kind == FK_CPU) ? cp_id : '0;
                epc_q  <= epc_in;
                if (loads_badaddr(kind)) bad_q <= bad_addr;
                if (is_tlb_kind(kind)) begin
                    hi_vpn_q  <= vpn2;
                    hi_asid_q <= asid;
                    ctx_vpn_q <= vpn2;
                end
            end
            if (swap) begin
                pss_q <= css_q;
                css_q <= ESS_INIT;
            end
        end
    end

    always_comb begin
        dbg_rdata = '0;
        unique case (dbg_sel)
            3'd0: begin
                dbg_rdata[ST_EXL_BIT] = exl_q;
                dbg_rdata[ST_BEV_BIT] = BEV_INIT;
                dbg_rdata[ST_CU1_BIT] = cu1_q;
            end
            3'd1: begin
                dbg_rdata[CA_BD_BIT]                 = bd_q;
                dbg_rdata[CA_CE_LSB +: CPID_W]       = ce_q;
                dbg_rdata[CA_IV_BIT]                 = IV_INIT;
                dbg_rdata[CA_EXC_LSB +: 5]           = code_q;
            end
            3'd2: dbg_rdata = epc_q;
            3'd3: dbg_rdata = bad_q;
            3'd4: begin
                dbg_rdata[HI_VPN_LSB +: VPN2_W] = hi_vpn_q;
                dbg_rdata[ASID_W-1:0]           = hi_asid_q;
            end
            3'd5: dbg_rdata[CTX_VPN_LSB +: VPN2_W] = ctx_vpn_q;
            3'd6: begin
                dbg_rdata[SH_CUR_LSB +: 4] = css_q;
                dbg_rdata[SH_PRV_LSB +: 4] = pss_q;
                dbg_rdata[SH_EXC_LSB +: 4] = ESS_INIT;
            end
            default: dbg_rdata = vbase_q;
        endcase
    end

    assign exl_o   = exl_q;
    assign bev_o   = BEV_INIT;
    assign iv_o    = IV_INIT;
    assign vbase_o = vbase_q;

    AST_EXL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> exl_q) else $error("EXL not set"); // R2
    AST_EXL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        exl_q |=> exl_q) else $error("EXL cleared"); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (exl_q || BEV_INIT)) |=> ($stable(css_q) && $stable(pss_q)))
        else $error("shadow changed"); // R3
    AST_CE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind != FK_CPU) |=> (ce_q == '0)) else $error("CE kept"); // R5
    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !loads_badaddr(kind)) |=> $stable(bad_q)) else $error("bad addr moved"); // R12
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter bit              BEV_INIT   = 1'b0,
    parameter bit              IV_INIT    = 1'b0,
    parameter logic [3:0]      CSS_INIT   = 4'd1,
    parameter logic [3:0]      ESS_INIT   = 4'd3,
    parameter logic [XLEN-1:0] VBASE_INIT = 32'h8000_0000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_valid,
    input  logic [3:0]        ent_kind,
    input  logic [CPID_W-1:0] ent_cp_id,
    input  logic [XLEN-1:0]   ent_addr,
    input  logic [VPN2_W-1:0] ent_vpn2,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_npc,
    input  logic              vbase_we,
    input  logic [XLEN-1:0]   vbase_wdata,
    input  logic [2:0]        dbg_sel,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   redir_npc,
    output logic [XLEN-1:0]   redir_nnpc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

    ctl_state_e      st_q, st_d;
    fault_kind_e     kind;
    logic            take, boot_evt;
    logic            exl, bev, iv;
    logic [XLEN-1:0] vbase, handler, target, epc;
    logic            in_slot;

    assign kind     = fault_kind_e'(ent_kind);
    assign take     = (st_q == ST_RUN) && ent_valid && (kind != FK_NONE) && (kind != FK_RESET);
    assign boot_evt = (st_q == ST_BOOT) || ((st_q == ST_RUN) && ent_valid && (kind == FK_RESET));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BOOT: st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BOOT;
        else        st_q <= st_d;
    end

    exc_epc_calc u_epc (
        .pc      (cur_pc),
        .npc     (cur_npc),
        .epc     (epc),
        .in_slot (in_slot)
    );

    exc_vector_sel u_vec (
        .kind       (kind),
        .exl_before (exl),
        .bev        (bev),
        .iv         (iv),
        .vbase      (vbase),
        .handler    (handler)
    );

    exc_csr_bank #(
        .BEV_INIT   (BEV_INIT),
        .IV_INIT    (IV_INIT),
        .CSS_INIT   (CSS_INIT),
        .ESS_INIT   (ESS_INIT),
        .VBASE_INIT (VBASE_INIT)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .boot_evt    (boot_evt),
        .kind        (kind),
        .cp_id       (ent_cp_id),
        .bad_addr    (ent_addr),
        .vpn2        (ent_vpn2),
        .asid        (ent_asid),
        .epc_in      (epc),
        .slot_in     (in_slot),
        .vbase_we    (vbase_we),
        .vbase_wdata (vbase_wdata),
        .dbg_sel     (dbg_sel),
        .dbg_rdata   (dbg_rdata),
        .exl_o       (exl),
        .bev_o       (bev),
        .iv_o        (iv),
        .vbase_o     (vbase)
    );

    assign target = boot_evt ? BOOT_VEC : handler;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_npc   <= '0;
            redir_nnpc  <= '0;
        end else begin
            redir_valid <= take || boot_evt;
            if (take || boot_evt) begin
                redir_pc   <= target;
                redir_npc  <= target + STEP;
                redir_nnpc <= target + STEP + STEP;
            end
        end
    end

    AST_REDIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_npc == redir_pc + STEP && redir_nnpc == redir_npc + STEP))
        else $error("redirect pcs not sequential"); // R11
    AST_REDIR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(take || boot_evt)) else $error("spurious redirect"); // R11
    AST_REDIR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_pc[6:0] == 7'd0)) else $error("misaligned handler"); // R7
    AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> (st_q == ST_RUN)) else $error("left run state"); // R1
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_valid = 1'b0;
    logic [3:0]  ent_kind = 4'd15;
    logic [1:0]  ent_cp_id = 2'd0;
    logic [31:0] ent_addr = '0;
    logic [18:0] ent_vpn2 = '0;
    logic [7:0]  ent_asid = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_npc = 32'd4;
    logic        vbase_we = 1'b0;
    logic [31:0] vbase_wdata = '0;
    logic [2:0]  dbg_sel = '0;

    logic [31:0] dbg_a, pc_a, npc_a, nnpc_a;
    logic [31:0] dbg_b, pc_b, npc_b, nnpc_b;
    logic        rv_a, rv_b;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_kind(ent_kind),
        .ent_cp_id(ent_cp_id), .ent_addr(ent_addr), .ent_vpn2(ent_vpn2), .ent_asid(ent_asid),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
        .dbg_sel(dbg_sel), .dbg_rdata(dbg_a), .redir_valid(rv_a), .redir_pc(pc_a),
        .redir_npc(npc_a), .redir_nnpc(nnpc_a));

    exc_entry_ctrl #(.BEV_INIT(1'b1), .IV_INIT(1'b1)) u_exc_entry_ctrl_bev (
        .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_kind(ent_kind),
        .ent_cp_id(ent_cp_id), .ent_addr(ent_addr), .ent_vpn2(ent_vpn2), .ent_asid(ent_asid),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
        .dbg_sel(dbg_sel), .dbg_rdata(dbg_b), .redir_valid(rv_b), .redir_pc(pc_b),
        .redir_npc(npc_b), .redir_nnpc(nnpc_b));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] a, output logic [31:0] b);
        dbg_sel = sel;
        #1;
        a = dbg_a;
        b = dbg_b;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ent_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
    endtask

    task automatic fire(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [31:0] addr, input logic [18:0] vpn, input logic [7:0] asid);
        @(negedge clk);
        ent_kind  = k;
        ent_cp_id = 2'd2;
        ent_addr  = addr;
        ent_vpn2  = vpn;
        ent_asid  = asid;
        cur_pc    = pc;
        cur_npc   = npc;
        ent_valid = 1'b1;
        @(posedge clk);
        #2;
        ent_valid = 1'b0;
    endtask

    function automatic logic [4:0] code_of(input int k);
        case (k)
            1: return 5'h1;  2: return 5'h2;  3: return 5'h3;
            4: return 5'h4;  5: return 5'h5;  6: return 5'h8;
            7: return 5'h9;  8: return 5'hA;  9: return 5'hB;
            10: return 5'hC; 11: return 5'hD; 12: return 5'h2;
            13: return 5'h3; default: return 5'h0;
        endcase
    endfunction

    function automatic logic [31:0] vec_of(input int k, input bit exlb, input bit bev,
                                           input bit iv, input logic [31:0] eb);
        if (k == 12 || k == 13) return exlb ? eb + 32'h180 : eb;
        if (k == 0) return iv ? eb + 32'h200 : eb + 32'h180;
        if (k == 10 && bev) return 32'hBFC0_0200;
        return eb + 32'h180;
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b, pc, npc, addr, epc, cau, ea, eb_exp;
        logic [18:0] vpn;
        logic [7:0]  asid;
        bit          slot, tlb, bad;

        // R1 boot redirect
        do_reset();
        chk("R1 boot valid A", {31'd0, rv_a}, 32'd1);
        chk("R1 boot pc A", pc_a, 32'hBFC0_0000);
        chk("R1 boot npc B", npc_b, 32'hBFC0_0004);
        chk("R1 boot nnpc B", nnpc_b, 32'hBFC0_0008);
        rd(3'd0, a, b);
        chk("R1 status A", a, 32'h2000_0000);
        chk("R1 status B", b, 32'h2040_0000);
        @(posedge clk); #2;
        chk("R11 boot pulse ends", {31'd0, rv_a}, 32'd0);

        // sweep every exception kind from a fresh reset on both configurations
        for (int k = 0; k < 14; k++) begin
            do_reset();
            pc   = 32'h0040_1000 + 32'(k) * 32;
            slot = (k % 2) == 1;
            npc  = slot ? pc + 32'h40 : pc + 4;
            addr = 32'hA000_0003 | (32'(k) << 8);
            vpn  = 19'h1_2340 + 19'(k);
            asid = 8'h50 + 8'(k);
            fire(4'(k), pc, npc, addr, vpn, asid);
            chk($sformatf("R11 valid k=%0d", k), {30'd0, rv_a, rv_b}, 32'd3);
            chk($sformatf("R7 R8 R9 vec A k=%0d", k), pc_a, vec_of(k, 0, 0, 0, 32'h8000_0000));
            chk($sformatf("R8 R9 R10 vec B k=%0d", k), pc_b, vec_of(k, 0, 1, 1, 32'h8000_0000));
            chk($sformatf("R11 nnpc B k=%0d", k), nnpc_b, vec_of(k, 0, 1, 1, 32'h8000_0000) + 8);
            epc = slot ? pc - 4 : pc;
            rd(3'd2, a, b);
            chk($sformatf("R4 epc k=%0d", k), a, epc);
            cau = (32'(slot) << 31) | (32'(code_of(k)) << 2) | ((k == 9) ? 32'h2000_0000 : 32'h0);
            rd(3'd1, a, b);
            chk($sformatf("R5 R6 cause A k=%0d", k), a, cau);
            chk($sformatf("R5 cause B k=%0d", k), b, cau | 32'h0080_0000);
            rd(3'd0, a, b);
            chk($sformatf("R2 status A k=%0d", k), a, 32'h2000_0002);
            rd(3'd6, a, b);
            chk($sformatf("R3 swap A k=%0d", k), a, 32'h0000_3043);
            chk($sformatf("R3 hold B k=%0d", k), b, 32'h0000_3001);
            tlb = (k >= 1 && k <= 3) || k == 12 || k == 13;
            bad = tlb || k == 4 || k == 5;
            rd(3'd3, a, b);
            chk($sformatf("R12 badaddr k=%0d", k), a, bad ? addr : 32'h0);
            rd(3'd4, a, b);
            ea = tlb ? ((32'(vpn) << 13) | 32'(asid)) : 32'h0;
            chk($sformatf("R12 entryhi k=%0d", k), a, ea);
            rd(3'd5, a, b);
            chk($sformatf("R12 context k=%0d", k), b, tlb ? (32'(vpn) << 4) : 32'h0);
        end

        // nested entries: EXL already set
        do_reset();
        fire(4'd6, 32'h100, 32'h104, 32'h0, 19'h0, 8'h0);
        fire(4'd12, 32'h200, 32'h204, 32'h0, 19'h0, 8'h0);
        chk("R8 nested refill vec", pc_a, 32'h8000_0180);
        rd(3'd6, a, b);
        chk("R3 nested no swap", a, 32'h0000_3043);
        rd(3'd0, a, b);
        chk("R2 EXL stays set", a, 32'h2000_0002);
        @(posedge clk); #2;
        chk("R11 pulse one cycle", {31'd0, rv_a}, 32'd0);

        // ignored kind
        fire(4'd15, 32'h300, 32'h3F0, 32'hDEAD_BEEF, 19'h7FFFF, 8'hFF);
        chk("R13 ignored no redirect", {30'd0, rv_a, rv_b}, 32'd0);
        rd(3'd1, a, b);
        chk("R13 ignored cause", a, 32'h0000_0008);
        rd(3'd2, a, b);
        chk("R13 ignored epc", a, 32'h0000_0200);
        rd(3'd3, a, b);
        chk("R13 ignored badaddr", a, 32'h0);

        // reset kind
        fire(4'd14, 32'h400, 32'h404, 32'h0, 19'h0, 8'h0);
        chk("R13 reset kind pc", pc_a, 32'hBFC0_0000);
        rd(3'd2, a, b);
        chk("R13 reset kind epc kept", a, 32'h0000_0200);

        // vector base write
        @(negedge clk);
        vbase_we = 1'b1;
        vbase_wdata = 32'h9000_0ABC;
        @(negedge clk);
        vbase_we = 1'b0;
        rd(3'd7, a, b);
        chk("R14 vbase masked", a, 32'h9000_0000);
        fire(4'd11, 32'h500, 32'h504, 32'h0, 19'h0, 8'h0);
        eb_exp = 32'h9000_0180;
        chk("R14 R7 new base vector", pc_a, eb_exp);
        fire(4'd0, 32'h600, 32'h604, 32'h0, 19'h0, 8'h0);
        chk("R9 iv vector new base", pc_b, 32'h9000_0200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule